// File: doc/BRIEF.md
# Range-Steered Radix-4 Booth Multiplier

This block multiplies two 16-bit two's-complement operands and returns the full 32-bit signed product one clock after the operands are presented. The multiplier uses radix-4 Booth recoding of one operand. The choice of which operand to recode is made per operation, from how many significant bits each operand carries above its sign extension.

A front stage measures this effective range for both inputs. It sends the operand with the smaller range to the Booth recoder and the other operand to the row generators. An operand with a small range yields only a few non-zero Booth digits. The rows for the digits above that range do not load new inputs. They keep the select and multiplicand values they last used, and they add zero to the sum.

The rows are summed by a chain of 3:2 carry-save counters, followed by one carry-propagate adder. The product and a valid flag are registered. A caller presents operands together with a strobe and reads the product in the next cycle. The product register keeps its value in cycles without a strobe.

Top module: `booth_drm_mult`

## Requirements
- R1: When `in_valid` is high at a rising edge, `product` after that edge equals the signed product of `op_a` and `op_b`, for every pair of 16-bit two's-complement values.
- R2: `out_valid` is high in exactly the cycles that follow a rising edge at which `in_valid` was high.
- R3: While `in_valid` is low, `product` keeps its previous value no matter how `op_a` and `op_b` change, and `out_valid` is low.
- R4: While `rst_n` is low, `out_valid` is 0 and `product` is 0.
- R5: The effective range of an operand is one plus the index of its highest bit that differs from bit 15, or 0 if no such bit exists. The operand with the strictly smaller range is recoded. On a tie, `op_a` is recoded. Swapping the operands never changes the product.
- R6: Digit j of the recoded operand is taken from bits 2j+1, 2j and 2j-1, with bit -1 read as zero. Its value is -2·b[2j+1] + b[2j] + b[2j-1], which lies in {-2..+2}. For a recoded range r, only the digits 0 to floor(r/2) are active. Inactive rows keep their stored inputs and contribute zero to the sum, so a product that follows a wide operation is still exact.
- R7: The corner operands are exact. This covers -32768 by -32768 (0x40000000), -32768 by 32767, the operands -1, 0 and 1, and operands whose range is the full 15 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 32 | Registered signed product |

## Verification
The operands are drawn from four sources. The first is a full cross of sixteen boundary values, covering sign extremes, alternating patterns, and values just inside and outside a byte. The second is a pseudo-random stream. The third is a staircase of operands whose effective range grows by one bit per step, paired in both orders with a full-range operand. This shows whether the choice of recoded operand and the count of active rows are right at every range, including the ties. The fourth makes a narrow multiply directly follow a wide one, which shows whether a frozen row leaks its stale contents into the sum. A final sequence drops the strobe and wiggles the operands, which separates a held product from one that is recomputed.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // One radix-4 Booth digit: magnitude select and sign
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  // Recode a bit triplet {hi, mid, lo} into a digit in {-2..+2}
  function automatic bdig_t recode(input logic [2:0] t);
    bdig_t d;
    d.neg = t[2] & ~(t[1] & t[0]);
    d.one = t[1] ^ t[0];
    d.two = (t == 3'b011) | (t == 3'b100);
    return d;
  endfunction

endpackage

// File: rtl/drange_sel.sv
module drange_sel #(
  parameter int W  = 16,
  parameter int ND = W / 2,
  parameter int DW = $clog2(ND + 1)
) (
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic [W-1:0]  rec_op,
  output logic [W-1:0]  pp_op,
  output logic [DW-1:0] n_active
);
  localparam int RW = $clog2(W + 1);

  function automatic logic [RW-1:0] eff_range(input logic [W-1:0] x);
    logic [RW-1:0] r;
    r = '0;
    for (int i = 0; i < W - 1; i++) begin
      if (x[i] != x[W-1]) r = RW'(i + 1);
    end
    return r;
  endfunction

  logic [RW-1:0] rng_a, rng_b, rng_min;
  logic          pick_b;

  always_comb begin
    rng_a    = eff_range(in_a);
    rng_b    = eff_range(in_b);
    pick_b   = rng_b < rng_a;
    rng_min  = pick_b ? rng_b : rng_a;
    rec_op   = pick_b ? in_b : in_a;
    pp_op    = pick_b ? in_a : in_b;
    n_active = DW'((rng_min >> 1) + 1'b1);
  end

endmodule

// File: rtl/booth_row.sv
module booth_row
  import booth_pkg::*;
#(
  parameter int W   = 16,
  parameter int J   = 0,
  parameter int PW  = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          upd,
  input  logic [2:0]    live_trip,
  input  logic [W-1:0]  live_m,
  output logic [PW-1:0] row
);
  logic [2:0]    trip_q, trip_d, trip_use;
  logic [W-1:0]  m_q, m_d, m_use;
  logic [PW-1:0] m_ext, mag, val;
  bdig_t         dig;

  // Stored inputs: loaded only when this row takes part
  always_comb begin
    trip_d = upd ? live_trip : trip_q;
    m_d    = upd ? live_m : m_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= '0;
      m_q    <= '0;
    end else begin
      trip_q <= trip_d;
      m_q    <= m_d;
    end
  end

  always_comb begin
    trip_use = act ? live_trip : trip_q;
    m_use    = act ? live_m : m_q;
    dig      = recode(trip_use);
    m_ext    = {{(PW-W){m_use[W-1]}}, m_use};
    mag      = dig.two ? (m_ext << 1) : (dig.one ? m_ext : '0);
    val      = dig.neg ? (~mag + 1'b1) : mag;
    row      = act ? (val << (2 * J)) : '0;
  end

endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int PW = 32,
  parameter int N  = 8
) (
  input  logic [N-1:0][PW-1:0] rows,
  output logic [PW-1:0]        total
);
  logic [N-1:0][PW-1:0] s_v;
  logic [N-1:0][PW-1:0] c_v;

  assign s_v[0] = rows[0];
  assign c_v[0] = '0;

  for (genvar i = 1; i < N; i++) begin : g_csa
    logic [PW-1:0] maj;
    assign s_v[i] = s_v[i-1] ^ c_v[i-1] ^ rows[i];
    assign maj    = (s_v[i-1] & c_v[i-1]) | (s_v[i-1] & rows[i]) | (c_v[i-1] & rows[i]);
    assign c_v[i] = {maj[PW-2:0], 1'b0};
  end

  assign total = s_v[N-1] + c_v[N-1];

endmodule

// File: rtl/booth_drm_mult.sv
module booth_drm_mult #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic             out_valid,
  output logic [2*W-1:0]   product
);
  localparam int ND = W / 2;
  localparam int PW = 2 * W;
  localparam int DW = $clog2(ND + 1);

  logic [W-1:0]         rec_op, pp_op;
  logic [DW-1:0]        n_active;
  logic [W:0]           rec_ext;
  logic [ND-1:0][PW-1:0] rows;
  logic [PW-1:0]        total;
  logic [PW-1:0]        prod_d;
  logic                 vld_d;

  drange_sel #(.W(W), .ND(ND), .DW(DW)) u_sel (
    .in_a     (op_a),
    .in_b     (op_b),
    .rec_op   (rec_op),
    .pp_op    (pp_op),
    .n_active (n_active)
  );

  assign rec_ext = {rec_op, 1'b0};

  for (genvar j = 0; j < ND; j++) begin : g_row
    logic act_j;
    assign act_j = DW'(j) < n_active;
    booth_row #(.W(W), .J(j), .PW(PW)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (act_j),
      .upd       (act_j & in_valid),
      .live_trip (rec_ext[2*j+2 -: 3]),
      .live_m    (pp_op),
      .row       (rows[j])
    );
  end

  csa_chain #(.PW(PW), .N(ND)) u_sum (
    .rows  (rows),
    .total (total)
  );

  always_comb begin
    vld_d  = in_valid;
    prod_d = in_valid ? total : product;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= vld_d;
      product   <= prod_d;
    end
  end

endmodule

// File: rtl/booth_drm_mult_chk.sv
module booth_drm_mult_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           out_valid,
  input logic [2*W-1:0] product
);
  logic signed [2*W-1:0] ref_prod;
  assign ref_prod = $signed({{W{op_a[W-1]}}, op_a}) * $signed({{W{op_b[W-1]}}, op_b});

  assert_exact_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> product == $past(ref_prod));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_product_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

endmodule

bind booth_drm_mult booth_drm_mult_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .product   (product)
);

// File: tb/booth_drm_mult_bench.sv
`timescale 1ns/1ps
module booth_drm_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] product;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  booth_drm_mult u_booth_drm_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  function automatic logic [15:0] edge_val(input int i);
    case (i)
      0: return 16'h0000;   1: return 16'h0001;   2: return 16'hFFFF;   3: return 16'h0002;
      4: return 16'hFFFE;   5: return 16'h7FFF;   6: return 16'h8000;   7: return 16'h00FF;
      8: return 16'hFF00;   9: return 16'h5555;  10: return 16'hAAAA;  11: return 16'h7FFE;
      12: return 16'h8001; 13: return 16'h0003;  14: return 16'h0100;  default: return 16'hFF7F;
    endcase
  endfunction

  function automatic logic [31:0] expect_of(input logic [15:0] x, input logic [15:0] y);
    int sx, sy;
    sx = $signed(x);
    sy = $signed(y);
    return 32'(sx * sy);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic mul(input logic [15:0] x, input logic [15:0] y, input string req);
    logic [31:0] e;
    e = expect_of(x, y);
    op_a = x; op_b = y; in_valid = 1'b1;
    @(negedge clk);
    chk(product == e, req, product, e);
    chk(out_valid == 1'b1, "R2", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    logic [15:0] lf;
    logic [31:0] held;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R4", {31'd0, out_valid}, 32'd0);
    chk(product == 32'd0, "R4", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", {31'd0, out_valid}, 32'd0);

    // R7 corners
    mul(16'h8000, 16'h8000, "R7");
    mul(16'h8000, 16'h7FFF, "R7");
    mul(16'h7FFF, 16'h7FFF, "R7");
    mul(16'hFFFF, 16'h8000, "R7");

    // R1 boundary cross
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        mul(edge_val(i), edge_val(j), "R1");

    // R5 / R6 range staircase, both orders, ties included
    for (int k = 0; k < 16; k++) begin
      logic [15:0] p, n;
      p = 16'((32'd1 << k) - 1);
      n = ~p;
      mul(p, 16'h6B3D, "R5");
      mul(16'h6B3D, p, "R5");
      mul(n, 16'h9C4B, "R5");
      mul(16'h9C4B, n, "R5");
      mul(p, n, "R5");
      // narrow after wide: frozen rows must add nothing stale
      mul(16'hA5A5, 16'h5A5A, "R6");
      mul(16'h7FFF, p, "R6");
      mul(16'hD3C1, 16'h8000, "R6");
      mul(n, 16'h7FFF, "R6");
    end

    // R1 pseudo-random stream
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      x = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mul(x, (i % 3 == 0) ? 16'(x >>> (i % 16)) : lf, "R1");
    end

    // R3 hold with strobe low
    mul(16'h1234, 16'hFEDC, "R1");
    held = product;
    in_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      op_a = 16'(i * 16'h3131); op_b = ~op_a;
      @(negedge clk);
      chk(product == held, "R3", product, held);
      chk(out_valid == 1'b0, "R3", {31'd0, out_valid}, 32'd0);
    end
    mul(16'h0005, 16'hFFFD, "R2");

    // R4 reset mid-run
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R4", {31'd0, out_valid}, 32'd0);
    chk(product == 32'd0, "R4", product, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule